// File: doc/BRIEF.md
# Glitch-Free Selectable Card Clock Divider

This block derives the clock sent to a contact card from a host-supplied input clock. A two-bit ratio select picks one of four output rates: the input divided by eight, four or two, or the input passed straight through. A power-down request parks the output at a programmable level, high or low. While the card slot is inactive, the output is held low.

Any change of ratio, and any entry into or exit from the parked state, is applied at one common point. That point is the input-clock rising edge at which every divided tap falls together, which is the wrap of a free-running phase counter. The pass-through path is gated by an enable that changes only while the input clock is low. As a result, no output high or low phase is ever cut short. The host may stop the input clock once the output is parked, and must restart it before it releases power-down.

Top module: `cardclk_div`

## Requirements
- R1: With select 00 the output period is 8 input periods, with 01 it is 4, and with 10 it is 2; in each of these the output is high for exactly half its period.
- R2: With select 11 the output follows the input clock, with the same period and the same high time, and no duty correction.
- R3: Across every ratio change, park, unpark, and a ratio change requested in the same cycle as a park or unpark, no output high or low phase is shorter than half an input period. Between divided ratios only, no phase is shorter than 45% of a divide-by-2 period.
- R4: With power-down requested and the stop-level input at 1, the output settles high within 8 input cycles and then makes no edges.
- R5: With power-down requested and the stop-level input at 0, the output settles low within 8 input cycles and then makes no edges. Changing the stop level while parked moves the output to the new level.
- R6: While parked, the input clock may stop; the output holds its parked level. After the clock restarts and power-down is released, the output resumes at the selected ratio.
- R7: With the slot inactive, the output goes low within 8 input cycles and stays low, even when power-down is requested with stop level 1.
- R8: While reset is asserted, and for the first cycles after its release, the output is low.
- R9: New select, power-down and stop-level values are applied only at the counter wrap, the edge at which all divided taps fall together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_in | input | 1 | Input clock from the host; it may be stopped while the output is parked |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| slot_en | input | 1 | Slot active; when low, the output is forced low |
| ratio_sel | input | 2 | Ratio select: 00 /8, 01 /4, 10 /2, 11 pass-through |
| pdown_req | input | 1 | Power-down request; parks the output |
| park_high | input | 1 | Parked level: 1 stops the output high, 0 stops it low |
| card_clk | output | 1 | Clock to the card |

## Verification
The function that most easily collides with another is a ratio change landing at the same wrap as a park or unpark. The bench provokes this by changing the select and the power-down request in one drive step: first from divide-by-2 into a low park, then out of the park directly into pass-through. An edge monitor measures the width of every output phase throughout the run and judges it against a floor of half an input period. The scoreboard then checks the parked level and the period and high time after the release.

// File: rtl/cardclk_pkg.sv
`timescale 1ns/1ps
package cardclk_pkg;
  // number of binary divider stages; the bypass code equals this value
  localparam int unsigned CCLK_STAGES = 3;

  typedef enum logic [1:0] {
    RATIO_8 = 2'b00,
    RATIO_4 = 2'b01,
    RATIO_2 = 2'b10,
    RATIO_1 = 2'b11
  } ratio_e;
endpackage

// File: rtl/cardclk_rst_sync.sv
`timescale 1ns/1ps
// Asynchronous assert, synchronous release of the block reset.
module cardclk_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [1:0] pipe_q;
  logic [1:0] pipe_d;

  always_comb pipe_d = {pipe_q[0], 1'b1};

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) pipe_q <= '0;
    else         pipe_q <= pipe_d;
  end

  assign srst_n = pipe_q[1];
endmodule

// File: rtl/cardclk_phase.sv
`timescale 1ns/1ps
// Free-running phase counter; its bits are the divided taps.
module cardclk_phase #(
  parameter int unsigned STAGES = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  output logic [STAGES-1:0] ph_d,
  output logic              wrap
);
  localparam logic [STAGES-1:0] PH_LAST = '1;
  localparam logic [STAGES-1:0] PH_ONE  = STAGES'(1);

  logic [STAGES-1:0] ph_q;

  always_comb begin
    ph_d = ph_q + PH_ONE;
    wrap = (ph_q == PH_LAST);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ph_q <= '0;
    else        ph_q <= ph_d;
  end
endmodule

// File: rtl/cardclk_ctrl.sv
`timescale 1ns/1ps
// Holds the applied ratio and park state; loads them only at the wrap.
module cardclk_ctrl #(
  parameter int unsigned SEL_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wrap,
  input  logic [SEL_W-1:0] sel_i,
  input  logic             park_req,
  input  logic             park_lvl_req,
  output logic [SEL_W-1:0] sel_q,
  output logic [SEL_W-1:0] sel_d,
  output logic             park_q,
  output logic             park_d,
  output logic             lvl_d
);
  logic lvl_q;

  always_comb begin
    sel_d  = sel_q;
    park_d = park_q;
    lvl_d  = lvl_q;
    if (wrap) begin
      sel_d  = sel_i;
      park_d = park_req;
      lvl_d  = park_lvl_req;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q  <= '0;
      park_q <= 1'b1;
      lvl_q  <= 1'b0;
    end else begin
      sel_q  <= sel_d;
      park_q <= park_d;
      lvl_q  <= lvl_d;
    end
  end
endmodule

// File: rtl/cardclk_out.sv
`timescale 1ns/1ps
// Output stage: registered divided level plus a falling-edge gate for pass-through.
module cardclk_out #(
  parameter int unsigned STAGES = 3,
  parameter int unsigned SEL_W  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [STAGES-1:0] ph_d,
  input  logic [SEL_W-1:0]  sel_d,
  input  logic              park_d,
  input  logic              lvl_d,
  input  logic [SEL_W-1:0]  sel_q,
  input  logic              park_q,
  output logic              qdiv_q,
  output logic              byp_en_q
);
  localparam logic [SEL_W-1:0] BYP_CODE = SEL_W'(STAGES);

  logic [STAGES-1:0] tap;
  logic              tap_lvl;
  logic              qdiv_d;
  logic              byp_d;

  // select code s picks the tap that divides by 2**(STAGES-s)
  for (genvar s = 0; s < STAGES; s++) begin : g_tap
    assign tap[s] = ph_d[STAGES-1-s];
  end

  always_comb begin
    tap_lvl = 1'b0;
    for (int s = 0; s < STAGES; s++) begin
      if (sel_d == SEL_W'(s)) tap_lvl = tap[s];
    end
    qdiv_d = park_d ? lvl_d : tap_lvl;
    byp_d  = !park_q && (sel_q >= BYP_CODE);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) qdiv_q <= 1'b0;
    else        qdiv_q <= qdiv_d;
  end

  // changes only while clk is low, so the AND gate in the top cannot chop a pulse
  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) byp_en_q <= 1'b0;
    else        byp_en_q <= byp_d;
  end
endmodule

// File: rtl/cardclk_div.sv
`timescale 1ns/1ps
module cardclk_div #(
  parameter  int unsigned STAGES = cardclk_pkg::CCLK_STAGES,
  localparam int unsigned SEL_W  = $clog2(STAGES + 1)
) (
  input  logic             clk_in,
  input  logic             rst_n,
  input  logic             slot_en,
  input  logic [SEL_W-1:0] ratio_sel,
  input  logic             pdown_req,
  input  logic             park_high,
  output logic             card_clk
);
  logic              srst_n;
  logic [STAGES-1:0] ph_d;
  logic              wrap;
  logic [SEL_W-1:0]  sel_q;
  logic [SEL_W-1:0]  sel_d;
  logic              park_q;
  logic              park_d;
  logic              lvl_d;
  logic              qdiv_q;
  logic              byp_en_q;
  logic              want_park;
  logic              want_lvl;

  // an inactive slot is a low park that overrides the requested level
  assign want_park = pdown_req | ~slot_en;
  assign want_lvl  = slot_en & park_high;

  cardclk_rst_sync u_rst (
    .clk    (clk_in),
    .arst_n (rst_n),
    .srst_n (srst_n)
  );

  cardclk_phase #(.STAGES(STAGES)) u_phase (
    .clk   (clk_in),
    .rst_n (srst_n),
    .ph_d  (ph_d),
    .wrap  (wrap)
  );

  cardclk_ctrl #(.SEL_W(SEL_W)) u_ctrl (
    .clk          (clk_in),
    .rst_n        (srst_n),
    .wrap         (wrap),
    .sel_i        (ratio_sel),
    .park_req     (want_park),
    .park_lvl_req (want_lvl),
    .sel_q        (sel_q),
    .sel_d        (sel_d),
    .park_q       (park_q),
    .park_d       (park_d),
    .lvl_d        (lvl_d)
  );

  cardclk_out #(.STAGES(STAGES), .SEL_W(SEL_W)) u_out (
    .clk      (clk_in),
    .rst_n    (srst_n),
    .ph_d     (ph_d),
    .sel_d    (sel_d),
    .park_d   (park_d),
    .lvl_d    (lvl_d),
    .sel_q    (sel_q),
    .park_q   (park_q),
    .qdiv_q   (qdiv_q),
    .byp_en_q (byp_en_q)
  );

  assign card_clk = (clk_in & byp_en_q) | qdiv_q;
endmodule

// File: rtl/cardclk_div_chk.sv
`timescale 1ns/1ps
module cardclk_div_chk #(
  parameter int unsigned STAGES = 3
) (
  input logic                           clk_in,
  input logic                           rst_raw_n,
  input logic                           rst_n,
  input logic                           slot_en,
  input logic                           wrap,
  input logic                           park_q,
  input logic                           qdiv,
  input logic                           byp_en,
  input logic                           card_clk,
  input logic [$clog2(STAGES+1)-1:0]    sel_q
);
  localparam int unsigned IDLE_LIM = (1 << STAGES) + 1;
  localparam int unsigned CW       = $clog2(IDLE_LIM + 1);

  logic [CW-1:0] idle_cnt;

  always_ff @(posedge clk_in or negedge rst_n) begin
    if (!rst_n)                       idle_cnt <= '0;
    else if (slot_en)                 idle_cnt <= '0;
    else if (idle_cnt != CW'(IDLE_LIM)) idle_cnt <= idle_cnt + CW'(1);
  end

  // R9
  cfg_at_wrap_chk: assert property (@(posedge clk_in) disable iff (!rst_n)
    !$stable(sel_q) |-> $past(wrap));

  // R4
  park_hold_chk: assert property (@(posedge clk_in) disable iff (!rst_n)
    (park_q && $past(park_q) && !$past(wrap)) |-> $stable(qdiv));

  // R2
  bypass_excl_chk: assert property (@(posedge clk_in) disable iff (!rst_n)
    byp_en |-> !qdiv);

  // R7
  inactive_low_chk: assert property (@(posedge clk_in) disable iff (!rst_n)
    (idle_cnt == CW'(IDLE_LIM)) |-> (!qdiv && !byp_en));

  // R8
  always @(posedge clk_in) begin
    if (!rst_raw_n) begin
      reset_low_chk: assert (!card_clk);
    end
  end
endmodule

bind cardclk_div cardclk_div_chk #(.STAGES(STAGES)) u_chk (
  .clk_in    (clk_in),
  .rst_raw_n (rst_n),
  .rst_n     (srst_n),
  .slot_en   (slot_en),
  .wrap      (wrap),
  .park_q    (park_q),
  .qdiv      (qdiv_q),
  .byp_en    (byp_en_q),
  .card_clk  (card_clk),
  .sel_q     (sel_q)
);

// File: tb/cardclk_div_test.sv
`timescale 1ns/1ps
module cardclk_div_test;
  import cardclk_pkg::*;

  logic       clk_in    = 1'b0;
  logic       run       = 1'b1;
  logic       rst_n     = 1'b0;
  logic       slot_en   = 1'b1;
  logic       pdown_req = 1'b0;
  logic       park_high = 1'b0;
  logic [1:0] ratio_sel = RATIO_8;
  logic       card_clk;

  cardclk_div uut (
    .clk_in    (clk_in),
    .rst_n     (rst_n),
    .slot_en   (slot_en),
    .ratio_sel (ratio_sel),
    .pdown_req (pdown_req),
    .park_high (park_high),
    .card_clk  (card_clk)
  );

  always #5 if (run) clk_in = ~clk_in;

  int checks = 0;
  int errors = 0;

  typedef struct {
    real   per;
    real   hi;
    string tag;
  } wave_t;
  wave_t exp_q[$];

  // edge monitor: counts output edges and flags narrow phases
  realtime last_edge = 0;
  int      edge_cnt  = 0;
  int      glitch_cnt = 0;
  real     thr       = 4.5;
  real     min_w     = 1.0e9;
  bit      mon_on    = 1'b0;

  always @(card_clk) begin
    if (mon_on) begin
      real w;
      w = $realtime - last_edge;
      if (w < min_w) min_w = w;
      if (w < thr) glitch_cnt++;
      edge_cnt++;
    end
    last_edge = $realtime;
  end

  // scoreboard monitor: measures one full output period per expected item
  initial begin
    forever begin
      realtime t0, t1, t2;
      wave_t   item;
      wait (exp_q.size() != 0);
      @(posedge card_clk); t0 = $realtime;
      @(negedge card_clk); t1 = $realtime;
      @(posedge card_clk); t2 = $realtime;
      item = exp_q.pop_front();
      checks++;
      if ((t2 - t0 - item.per) > 0.01 || (item.per - (t2 - t0)) > 0.01 ||
          (t1 - t0 - item.hi) > 0.01 || (item.hi - (t1 - t0)) > 0.01) begin
        errors++;
        $display("FAIL %s: period %0.1f high %0.1f, expected period %0.1f high %0.1f",
                 item.tag, t2 - t0, t1 - t0, item.per, item.hi);
      end
    end
  end

  task automatic expect_wave(real per, real hi, string tag);
    wave_t it;
    it.per = per; it.hi = hi; it.tag = tag;
    exp_q.push_back(it);
    wait (exp_q.size() == 0);
    #1;
  endtask

  task automatic chk(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic cyc(int n);
    repeat (n) @(posedge clk_in);
    #2;
  endtask

  task automatic park_check(logic lvl, string tag);
    int e0;
    cyc(20);
    e0 = edge_cnt;
    cyc(30);
    chk(card_clk == lvl, {tag, " level"}, int'(card_clk), int'(lvl));
    chk(edge_cnt == e0, {tag, " no edges"}, edge_cnt - e0, 0);
  endtask

  task automatic stop_and_hold(logic lvl, string tag);
    int e0;
    run = 1'b0;
    e0 = edge_cnt;
    #300;
    chk(card_clk == lvl, {tag, " level with clock stopped"}, int'(card_clk), int'(lvl));
    chk(edge_cnt == e0, {tag, " no edges with clock stopped"}, edge_cnt - e0, 0);
    run = 1'b1;
    cyc(4);
  endtask

  initial begin
    // R8: reset state
    #12;
    chk(card_clk == 1'b0, "R8 low in reset", int'(card_clk), 0);
    cyc(3);
    chk(card_clk == 1'b0, "R8 low in reset later", int'(card_clk), 0);
    rst_n = 1'b1;
    mon_on = 1'b1;
    cyc(2);
    chk(card_clk == 1'b0, "R8 low after release", int'(card_clk), 0);

    // R1: divided ratios, judged with the divided-only floor of R3
    thr = 9.0;
    cyc(24);
    expect_wave(80.0, 40.0, "R1 div8");
    ratio_sel = RATIO_4; cyc(20);
    expect_wave(40.0, 20.0, "R1 div4");
    ratio_sel = RATIO_2; cyc(20);
    expect_wave(20.0, 10.0, "R1 div2");
    // R3: divided-only switches at scattered offsets
    for (int i = 0; i < 9; i++) begin
      ratio_sel = 2'(i % 3);
      cyc(3 + i);
    end
    ratio_sel = RATIO_8; cyc(24);
    expect_wave(80.0, 40.0, "R1 div8 after switching");

    // R2: pass-through, switched in and out at scattered offsets
    thr = 4.5;
    ratio_sel = RATIO_1; cyc(20);
    expect_wave(10.0, 5.0, "R2 pass-through");
    for (int i = 0; i < 8; i++) begin
      ratio_sel = (i % 2 == 0) ? RATIO_8 : RATIO_1;
      cyc(5 + 2 * i);
    end
    ratio_sel = RATIO_1; cyc(20);
    expect_wave(10.0, 5.0, "R2 pass-through again");

    // R4 from pass-through, then R5 by changing the level while parked
    pdown_req = 1'b1; park_high = 1'b1;
    park_check(1'b1, "R4 park high");
    park_high = 1'b0;
    park_check(1'b0, "R5 park low");

    // R6: stop the input clock while parked low, resume at /4
    stop_and_hold(1'b0, "R6");
    pdown_req = 1'b0; ratio_sel = RATIO_4; cyc(24);
    expect_wave(40.0, 20.0, "R6 resume div4");

    // R6 with a high park
    pdown_req = 1'b1; park_high = 1'b1;
    park_check(1'b1, "R4 park high from div4");
    stop_and_hold(1'b1, "R6 high");
    pdown_req = 1'b0; ratio_sel = RATIO_2; cyc(24);
    expect_wave(20.0, 10.0, "R6 resume div2");

    // R3: ratio change and park in one cycle, then unpark and ratio change together
    ratio_sel = RATIO_8; pdown_req = 1'b1; park_high = 1'b0;
    park_check(1'b0, "R3 park with ratio change");
    ratio_sel = RATIO_1; pdown_req = 1'b0; cyc(20);
    expect_wave(10.0, 5.0, "R3 unpark into pass-through");

    // R7: inactive slot forces low, overriding a high park
    slot_en = 1'b0; park_high = 1'b1;
    park_check(1'b0, "R7 inactive");
    pdown_req = 1'b1;
    park_check(1'b0, "R7 inactive over park high");
    slot_en = 1'b1; pdown_req = 1'b0; ratio_sel = RATIO_2; cyc(24);
    expect_wave(20.0, 10.0, "R7 reactivated div2");

    // R3: no narrow phase seen anywhere in the run
    chk(glitch_cnt == 0, "R3 narrow phases", glitch_cnt, 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #1000000;
    errors++;
    $display("FAIL watchdog: run did not complete, actual hung expected done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule